// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock for Unequal-Latency Execution Paths

This block sits in the decode stage of a pipeline that issues instructions in program order. The instructions then run down execution paths of different lengths: a single-stage integer path, a pipelined floating-point adder of four stages, a pipelined floating-point multiplier of seven stages, and a floating-point divider that is not pipelined and stays busy for twenty-four cycles. In each cycle the block looks at the decoded instruction: its unit class, whether it writes a register, its destination and its two source registers. It then decides whether that instruction may leave decode this cycle or must wait.

The block follows the destination tag of every in-flight instruction as the tag moves from stage to stage. It also keeps a reservation of the future cycles in which the single write-back port is already taken. When an instruction must wait, it stays in decode and the execution paths receive a bubble. A stall-cause code reports which check held the instruction back. The checks have a fixed order: the unit is busy, then an operand is not ready, then an earlier write to the same register is still in flight, then the write-back port is taken. The block also drives the write-back port itself, giving the destination of the instruction that completes in each cycle. Register operands are read in decode, so an overlap of a write after a read needs no check.

Top module: `fp_issue_interlock`

## Requirements
- R1: When `dec_valid` is high and no hazard exists, `issue` is 1, `stall` is 0 and `stall_why` is 0 in the same cycle. When `dec_valid` is low, `issue`, `stall` and `stall_why` are all 0, whatever the other decode inputs are.
- R2: The adder path (unit code 1) accepts a new instruction in every cycle. An add that issues in cycle t shows `wb_valid`=1 with its destination on `wb_dst` in cycle t+5.
- R3: The multiplier path (unit code 2) accepts a new instruction in every cycle. A multiply that issues in cycle t completes on the write-back port in cycle t+8.
- R4: An integer instruction (unit code 0) that issues in cycle t completes on the write-back port in cycle t+2.
- R5: A divide (unit code 3) that issues in cycle t completes in cycle t+25. A second divide presented from cycle t+1 on stalls with `stall_why`=1 for 24 cycles and issues in cycle t+25.
- R6: An instruction stalls with `stall_why`=2 while either of its source registers equals the destination of an instruction in the integer stage, an adder stage, a multiplier stage or the divider. It issues in the cycle in which that producer is on the write-back port.
- R7: An instruction that writes a register stalls with `stall_why`=3 while an instruction in an adder stage, a multiplier stage or the divider has the same destination. An in-flight integer instruction never causes this stall.
- R8: An instruction that writes a register stalls with `stall_why`=4 when its completion cycle equals the completion cycle of an instruction already issued. No two instructions ever share a write-back cycle.
- R9: When several hazards apply at once, `stall_why` reports the first of: busy unit (1), operand not ready (2), pending write to the same register (3), write-back port taken (4).
- R10: An instruction with `dec_has_dst`=0 is never stalled by the checks of R7 or R8, and it never produces a write-back.
- R11: A stalled instruction puts nothing into the execution paths: no write-back appears for a stall cycle.
- R12: Synchronous reset (`rst` high at a clock edge) discards every in-flight instruction and frees the divider. After reset no write-back appears for the discarded work, and a divide reading a discarded destination issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_unit | input | 2 | Unit class: 0 integer, 1 add, 2 multiply, 3 divide |
| dec_has_dst | input | 1 | The instruction writes a register |
| dec_dst | input | TAG_W (5) | Destination register |
| dec_src_a | input | TAG_W (5) | First source register |
| dec_src_b | input | TAG_W (5) | Second source register |
| stall | output | 1 | The decoded instruction must wait in decode |
| issue | output | 1 | The decoded instruction leaves decode at this edge |
| stall_why | output | 3 | Stall cause: 0 none, 1 unit busy, 2 operand, 3 same destination, 4 port taken |
| wb_valid | output | 1 | An instruction completes this cycle |
| wb_dst | output | TAG_W (5) | Destination register of the completing instruction |

## Verification
A tag lost from a stage shows up at the ports as a consumer that issues too early, so its stall count comes out short. A tag that sticks shows up as a stall count that runs long. Either one is visible in the very cycle the dependent instruction is presented. A wrong divider count or a wrong reservation bit moves the cycle of a write-back, or makes a stall of cause 4 appear or vanish. This shows up no later than the producer's completion cycle, at most 25 cycles after it issues. The bench sweeps every producer unit against consumers presented at chosen gaps. For each case it compares the exact number of stall cycles, the cause code and the cycle and destination of every write-back against values worked out from the latencies.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

   typedef enum logic [1:0] {
      UNIT_INT = 2'd0,
      UNIT_ADD = 2'd1,
      UNIT_MUL = 2'd2,
      UNIT_DIV = 2'd3
   } unit_e;

   typedef enum logic [2:0] {
      WAIT_NONE   = 3'd0,
      WAIT_UNIT   = 3'd1,
      WAIT_RAW    = 3'd2,
      WAIT_WAW    = 3'd3,
      WAIT_WBPORT = 3'd4
   } wait_e;

endpackage

// File: rtl/fpil_tag_pipe.sv
module fpil_tag_pipe #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 5
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_vld,
   input  logic [TAG_W-1:0]             in_tag,
   output logic [DEPTH-1:0]             stg_vld,
   output logic [DEPTH-1:0][TAG_W-1:0]  stg_tag
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("fpil_tag_pipe: DEPTH must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("fpil_tag_pipe: TAG_W must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst) stg_vld <= '0;
         else     stg_vld <= in_vld;
         stg_tag[0] <= in_tag;
      end
   end else begin : g_chain
      always_ff @(posedge clk) begin
         if (rst) stg_vld <= '0;
         else     stg_vld <= {stg_vld[DEPTH-2:0], in_vld};
         stg_tag <= {stg_tag[DEPTH-2:0], in_tag};
      end
   end

endmodule

// File: rtl/fpil_div_slot.sv
module fpil_div_slot #(
   parameter int CYCLES = 24,
   parameter int TAG_W  = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             load_vld,
   input  logic [TAG_W-1:0] load_tag,
   output logic             busy,
   output logic             fin,
   output logic             tag_vld,
   output logic [TAG_W-1:0] tag
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("fpil_div_slot: CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         tag_vld <= 1'b0;
      end else if (load) begin
         cnt     <= CNT_W'(CYCLES);
         tag_vld <= load_vld;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
         if (cnt == CNT_W'(1)) tag_vld <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (load) tag <= load_tag;
   end

   assign busy = (cnt != '0);
   assign fin  = (cnt == CNT_W'(1)) && tag_vld;

   // R5
   div_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      load |-> !busy);

   // R5
   div_release_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt == CNT_W'(1)) |=> !busy);

endmodule

// File: rtl/fpil_wb_reserve.sv
module fpil_wb_reserve #(
   parameter int SLOTS = 24,
   parameter int LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             book,
   input  logic [LAT_W-1:0] book_lat,
   input  logic [LAT_W-1:0] query_lat,
   output logic             clash
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("fpil_wb_reserve: SLOTS must be at least 2");
   end
   if ((1 << LAT_W) <= SLOTS) begin : g_bad_latw
      $error("fpil_wb_reserve: LAT_W too narrow for SLOTS");
   end

   // slot j set: a write-back is due j+1 edges from now
   logic [SLOTS-1:0] res;
   logic [SLOTS-1:0] res_nxt;

   always_comb begin
      res_nxt = {1'b0, res[SLOTS-1:1]};
      for (int j = 0; j < SLOTS; j++) begin
         if (book && (book_lat == LAT_W'(j + 1))) res_nxt[j] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) res <= '0;
      else     res <= res_nxt;
   end

   always_comb begin
      clash = 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
         if (query_lat == LAT_W'(j)) clash = res[j];
      end
   end

   // R8
   wb_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
      (book && (book_lat == query_lat)) |-> !clash);

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
   import fpil_pkg::*;
#(
   parameter int TAG_W      = 5,
   parameter int ADD_DEPTH  = 4,
   parameter int MUL_DEPTH  = 7,
   parameter int DIV_CYCLES = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dec_valid,
   input  logic [1:0]       dec_unit,
   input  logic             dec_has_dst,
   input  logic [TAG_W-1:0] dec_dst,
   input  logic [TAG_W-1:0] dec_src_a,
   input  logic [TAG_W-1:0] dec_src_b,
   output logic             stall,
   output logic             issue,
   output logic [2:0]       stall_why,
   output logic             wb_valid,
   output logic [TAG_W-1:0] wb_dst
);

   localparam int EX_DEPTH = 1;
   localparam int AM_MAX   = (ADD_DEPTH > MUL_DEPTH) ? ADD_DEPTH : MUL_DEPTH;
   localparam int MAX_LAT  = (AM_MAX > DIV_CYCLES) ? AM_MAX : DIV_CYCLES;
   localparam int LAT_W    = $clog2(MAX_LAT + 1);

   if (ADD_DEPTH < 1 || MUL_DEPTH < 1) begin : g_bad_pipes
      $error("fp_issue_interlock: pipelined paths need at least one stage");
   end
   if (DIV_CYCLES < 2) begin : g_bad_div
      $error("fp_issue_interlock: DIV_CYCLES must be at least 2");
   end

   logic [EX_DEPTH-1:0]               ex_v;
   logic [EX_DEPTH-1:0][TAG_W-1:0]    ex_t;
   logic [ADD_DEPTH-1:0]              add_v;
   logic [ADD_DEPTH-1:0][TAG_W-1:0]   add_t;
   logic [MUL_DEPTH-1:0]              mul_v;
   logic [MUL_DEPTH-1:0][TAG_W-1:0]   mul_t;
   logic                              div_busy, div_fin, div_tv;
   logic [TAG_W-1:0]                  div_t;
   logic [LAT_W-1:0]                  cur_lat;
   logic                              raw_hit, waw_hit, port_clash, unit_busy;
   logic                              ex_fin, add_fin, mul_fin;
   logic [TAG_W-1:0]                  fin_tag;
   wait_e                             why;

   always_comb begin
      case (dec_unit)
         2'd0:    cur_lat = LAT_W'(EX_DEPTH);
         2'd1:    cur_lat = LAT_W'(ADD_DEPTH);
         2'd2:    cur_lat = LAT_W'(MUL_DEPTH);
         default: cur_lat = LAT_W'(DIV_CYCLES);
      endcase
   end

   // operand and same-destination scan over every in-flight tag
   always_comb begin
      raw_hit = 1'b0;
      waw_hit = 1'b0;
      for (int i = 0; i < EX_DEPTH; i++) begin
         if (ex_v[i] && (ex_t[i] == dec_src_a || ex_t[i] == dec_src_b)) raw_hit = 1'b1;
      end
      for (int i = 0; i < ADD_DEPTH; i++) begin
         if (add_v[i]) begin
            if (add_t[i] == dec_src_a || add_t[i] == dec_src_b) raw_hit = 1'b1;
            if (add_t[i] == dec_dst) waw_hit = 1'b1;
         end
      end
      for (int i = 0; i < MUL_DEPTH; i++) begin
         if (mul_v[i]) begin
            if (mul_t[i] == dec_src_a || mul_t[i] == dec_src_b) raw_hit = 1'b1;
            if (mul_t[i] == dec_dst) waw_hit = 1'b1;
         end
      end
      if (div_tv) begin
         if (div_t == dec_src_a || div_t == dec_src_b) raw_hit = 1'b1;
         if (div_t == dec_dst) waw_hit = 1'b1;
      end
      if (!dec_has_dst) waw_hit = 1'b0;
   end

   assign unit_busy = (dec_unit == UNIT_DIV) && div_busy;

   always_comb begin
      why = WAIT_NONE;
      if (dec_valid) begin
         if (unit_busy)                      why = WAIT_UNIT;
         else if (raw_hit)                   why = WAIT_RAW;
         else if (waw_hit)                   why = WAIT_WAW;
         else if (dec_has_dst && port_clash) why = WAIT_WBPORT;
      end
   end

   assign stall_why = why;
   assign stall     = (why != WAIT_NONE);
   assign issue     = dec_valid && !stall;

   fpil_tag_pipe #(.DEPTH(EX_DEPTH), .TAG_W(TAG_W)) u_ex_pipe (
      .clk(clk), .rst(rst),
      .in_vld(issue && dec_has_dst && (dec_unit == UNIT_INT)),
      .in_tag(dec_dst), .stg_vld(ex_v), .stg_tag(ex_t));

   fpil_tag_pipe #(.DEPTH(ADD_DEPTH), .TAG_W(TAG_W)) u_add_pipe (
      .clk(clk), .rst(rst),
      .in_vld(issue && dec_has_dst && (dec_unit == UNIT_ADD)),
      .in_tag(dec_dst), .stg_vld(add_v), .stg_tag(add_t));

   fpil_tag_pipe #(.DEPTH(MUL_DEPTH), .TAG_W(TAG_W)) u_mul_pipe (
      .clk(clk), .rst(rst),
      .in_vld(issue && dec_has_dst && (dec_unit == UNIT_MUL)),
      .in_tag(dec_dst), .stg_vld(mul_v), .stg_tag(mul_t));

   fpil_div_slot #(.CYCLES(DIV_CYCLES), .TAG_W(TAG_W)) u_div (
      .clk(clk), .rst(rst),
      .load(issue && (dec_unit == UNIT_DIV)),
      .load_vld(dec_has_dst), .load_tag(dec_dst),
      .busy(div_busy), .fin(div_fin), .tag_vld(div_tv), .tag(div_t));

   fpil_wb_reserve #(.SLOTS(MAX_LAT), .LAT_W(LAT_W)) u_wb_res (
      .clk(clk), .rst(rst),
      .book(issue && dec_has_dst), .book_lat(cur_lat),
      .query_lat(cur_lat), .clash(port_clash));

   assign ex_fin  = ex_v[EX_DEPTH-1];
   assign add_fin = add_v[ADD_DEPTH-1];
   assign mul_fin = mul_v[MUL_DEPTH-1];

   always_comb begin
      fin_tag = '0;
      if (ex_fin)  fin_tag = ex_t[EX_DEPTH-1];
      if (add_fin) fin_tag = add_t[ADD_DEPTH-1];
      if (mul_fin) fin_tag = mul_t[MUL_DEPTH-1];
      if (div_fin) fin_tag = div_t;
   end

   always_ff @(posedge clk) begin
      if (rst) wb_valid <= 1'b0;
      else     wb_valid <= ex_fin | add_fin | mul_fin | div_fin;
      wb_dst <= fin_tag;
   end

   // R8
   wb_single_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ex_fin, add_fin, mul_fin, div_fin}));

   // R4
   int_wb_time_chk: assert property (@(posedge clk) disable iff (rst)
      (issue && dec_has_dst && (dec_unit == UNIT_INT)) |=> ##1
         (wb_valid && (wb_dst == $past(dec_dst, 2))));

endmodule

// File: tb/fp_issue_interlock_tb.sv
`timescale 1ns/1ps
module fp_issue_interlock_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dec_valid = 1'b0;
   logic [1:0] dec_unit = 2'd0;
   logic       dec_has_dst = 1'b0;
   logic [4:0] dec_dst = 5'd0;
   logic [4:0] dec_src_a = 5'd0;
   logic [4:0] dec_src_b = 5'd0;
   logic       stall, issue, wb_valid;
   logic [2:0] stall_why;
   logic [4:0] wb_dst;

   int n_chk = 0;
   int n_fail = 0;
   logic       wbv [64];
   logic [4:0] wbd [64];

   always #4 clk = ~clk;

   fp_issue_interlock u_dut (
      .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
      .dec_has_dst(dec_has_dst), .dec_dst(dec_dst), .dec_src_a(dec_src_a),
      .dec_src_b(dec_src_b), .stall(stall), .issue(issue), .stall_why(stall_why),
      .wb_valid(wb_valid), .wb_dst(wb_dst));

   function automatic int lat(input int u);
      return (u == 0) ? 1 : (u == 1) ? 4 : (u == 2) ? 7 : 24;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input bit v, input int u, input bit hd, input int d,
                        input int a, input int b);
      dec_valid = v; dec_unit = u[1:0]; dec_has_dst = hd;
      dec_dst = d[4:0]; dec_src_a = a[4:0]; dec_src_b = b[4:0];
   endtask

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic do_reset();
      rst = 1'b1; drive(0, 0, 0, 0, 0, 0);
      tick(); tick();
      rst = 1'b0;
   endtask

   task automatic clear_log();
      for (int k = 0; k < 64; k++) begin wbv[k] = 1'b0; wbd[k] = 5'd0; end
   endtask

   // producer writes r5 in cycle 0; consumer presented from cycle 1+gap
   task automatic scen(input string req, input int pu, input int gap, input int cu,
                       input bit chd, input int cd, input int ca, input int cb,
                       input int exp_st, input int exp_why);
      int c, n, ci, last_why, bad, bad_k, ev;
      bit why_ok, idle_ok;
      logic [4:0] ed;
      do_reset();
      clear_log();
      drive(1, pu, 1, 5, 1, 2); #1;
      chk(issue === 1'b1 && stall === 1'b0 && stall_why === 3'd0, "R1",
          "producer issue", int'(issue), 1);
      tick(); c = 1;
      idle_ok = 1'b1;
      for (int k = 0; k < gap; k++) begin
         drive(0, cu, chd, cd, 5, 5); #1;
         wbv[c] = wb_valid; wbd[c] = wb_dst;
         if (stall !== 1'b0 || issue !== 1'b0 || stall_why !== 3'd0) idle_ok = 1'b0;
         tick(); c++;
      end
      if (gap > 0) chk(idle_ok, "R1", "idle cycles quiet", int'(idle_ok), 1);
      ci = -1; n = 0; why_ok = 1'b1; last_why = 0;
      while (c < 63 && ci < 0) begin
         drive(1, cu, chd, cd, ca, cb); #1;
         wbv[c] = wb_valid; wbd[c] = wb_dst;
         if (issue === 1'b1) ci = c;
         else begin
            n++; last_why = int'(stall_why);
            if (stall !== 1'b1 || stall_why !== exp_why[2:0]) why_ok = 1'b0;
         end
         tick(); c++;
      end
      chk(n == exp_st, req, "stall cycles", n, exp_st);
      if (exp_st > 0) chk(why_ok, {req, " R9"}, "stall cause", last_why, exp_why);
      while (c < 64) begin
         drive(0, 0, 0, 0, 0, 0); #1;
         wbv[c] = wb_valid; wbd[c] = wb_dst;
         tick(); c++;
      end
      bad = 0; bad_k = 0;
      for (int k = 1; k < 64; k++) begin
         ev = 0; ed = 5'd0;
         if (k == lat(pu) + 1) begin ev = 1; ed = 5'd5; end
         if (chd && ci > 0 && k == ci + lat(cu) + 1) begin ev = 1; ed = cd[4:0]; end
         if (wbv[k] !== ev[0] || (ev == 1 && wbd[k] !== ed)) begin
            if (bad == 0) bad_k = k;
            bad++;
         end
      end
      chk(bad == 0, {req, " R4 R11"}, "write-back timing (first bad cycle)", bad_k, 0);
   endtask

   initial begin
      int bad;
      do_reset();
      #1;
      // R12 reset state
      chk(wb_valid === 1'b0 && stall === 1'b0 && issue === 1'b0, "R12",
          "reset state", int'(wb_valid), 0);

      // R6 operand sweep over every producer unit and both source positions
      for (int pu = 0; pu < 4; pu++) begin
         for (int pos = 0; pos < 2; pos++) begin
            scen("R6", pu, 0, 0, 1, 9, pos ? 1 : 5, pos ? 5 : 2, lat(pu), 2);
         end
      end
      // R7 same-destination sweep
      for (int pu = 1; pu < 4; pu++) scen("R7", pu, 0, 1, 1, 5, 1, 2, lat(pu), 3);
      scen("R7", 0, 0, 1, 1, 5, 1, 2, 0, 0);
      scen("R7", 1, 0, 0, 1, 5, 1, 2, 4, 3);
      // R5 divider occupancy
      scen("R5", 3, 0, 3, 1, 9, 1, 2, 24, 1);
      // R8 write-back port collisions
      scen("R8", 2, 2, 1, 1, 9, 1, 2, 1, 4);
      scen("R8", 1, 2, 0, 1, 9, 1, 2, 1, 4);
      scen("R8", 3, 16, 2, 1, 9, 1, 2, 1, 4);
      // R10 no-destination instructions
      scen("R10", 2, 2, 1, 0, 9, 1, 2, 0, 0);
      scen("R10", 1, 0, 0, 0, 5, 1, 2, 0, 0);
      // R9 priority
      scen("R9", 3, 0, 3, 1, 9, 5, 2, 24, 1);
      scen("R9", 1, 0, 1, 1, 5, 5, 2, 4, 2);

      // R2 R3 back-to-back issue
      do_reset(); clear_log();
      bad = 0;
      for (int c = 0; c < 40; c++) begin
         if (c < 3)      drive(1, 1, 1, 10 + c, 1, 2);
         else if (c < 5) drive(1, 2, 1, 17 + c, 1, 2);
         else            drive(0, 0, 0, 0, 0, 0);
         #1;
         wbv[c] = wb_valid; wbd[c] = wb_dst;
         if (c < 5 && issue !== 1'b1) bad++;
         tick();
      end
      chk(bad == 0, "R2 R3", "back-to-back issue misses", bad, 0);
      bad = 0;
      for (int k = 0; k < 40; k++) begin
         logic ev; logic [4:0] ed;
         ev = 1'b0; ed = 5'd0;
         if (k >= 5 && k <= 7)   begin ev = 1'b1; ed = 5'(10 + k - 5); end
         if (k == 11 || k == 12) begin ev = 1'b1; ed = 5'(20 + k - 11); end
         if (wbv[k] !== ev || (ev && wbd[k] !== ed)) bad++;
      end
      chk(bad == 0, "R2 R3", "pipelined write-back cycles wrong", bad, 0);

      // R12 reset discards in-flight work
      do_reset();
      drive(1, 3, 1, 5, 1, 2); tick();
      drive(0, 0, 0, 0, 0, 0); tick(); tick(); tick();
      rst = 1'b1; tick(); rst = 1'b0;
      drive(1, 3, 1, 6, 5, 2); #1;
      chk(issue === 1'b1 && stall_why === 3'd0, "R12", "divide after reset issues",
          int'(stall_why), 0);
      tick();
      bad = 0;
      for (int k = 0; k < 24; k++) begin
         drive(0, 0, 0, 0, 0, 0); #1;
         if (wb_valid !== 1'b0) bad++;
         tick();
      end
      chk(bad == 0, "R12", "write-backs from discarded work", bad, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule